// File: doc/BRIEF.md
# Multi-PHY Cell Receive Port

This block is the physical-layer end of a byte-wide cell bus on the receive path, shared by several physical ports behind one set of bus pins. It hosts two logical ports by default. Each port has its own programmable 5-bit bus address. The ATM-layer master polls an address and gets back one cell-available flag. It then selects a port by presenting that port's address while the active-low enable is high. After that it pulls the port's buffered 53-byte cell one byte per clock by holding the enable low.

Each port reads its cell from a simple show-ahead buffer. The buffer presents the head byte and a flag that says a complete, unstarted cell is waiting. The port pops one byte for every byte it transfers. The block does not contain the pad drivers. Every bus output comes with an output-enable, and the pad ring outside the block turns that enable into high impedance. One configuration bit releases all bus outputs at once.

Top module: `mphyRxPort`

## Requirements
- R1: On each clock edge the block registers a poll result for the bus address. In the following cycle `busClavOe` is 1 only if the address equals one of the port addresses, where port p's address is `cfgAddr[p*5+4:p*5]`. In that case `busClav` is 1 when the addressed port is part-way through a cell or has `cellReady` set, and 0 otherwise.
- R2: On a clock edge where `busEnN` is 1, the matching port (if any) becomes the selected port. While `busEnN` stays 0, the selection does not change, whatever address is on the bus.
- R3: A byte transfer happens on a clock edge where `busEnN` is 0, a port is selected, and that port is either part-way through a cell or has `cellReady` set. On that edge `bufRdEn` is a one-hot pulse for the selected port, and the popped byte appears on `busData` with `busDataOe` = 1 in the next cycle. In any cycle that follows an edge with no transfer, `busDataOe` is 0.
- R4: `busSoc` is 1 with the first byte of a cell and 0 with every later byte.
- R5: A cell is 53 bytes long. The edge that transfers byte 53 also clears the selection, so further edges with the enable low transfer nothing until a port is selected again.
- R6: `busClav` stays 1 for the addressed port through every byte of its cell, including the cycle that carries byte 53. Once the cell ends, `busClav` shows whether another complete cell is waiting.
- R7: Each port keeps its own byte offset. A cell that is interrupted, for example by a transfer from the other port, resumes where it stopped, and `busSoc` is not raised again.
- R8: When `cfgFloat` is 1, both `busDataOe` and `busClavOe` are 0.
- R9: When two ports are given the same address, the lower-numbered port answers polls and is the one selected.
- R10: While reset is held, both output enables are 0 and `bufRdEn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus byte clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 5 | Address presented by the master, used for polling and selection |
| busEnN | input | 1 | Active-low transfer enable from the master |
| busData | output | 8 | Cell byte to the master |
| busSoc | output | 1 | First-byte-of-cell marker |
| busDataOe | output | 1 | Drive enable for `busData` and `busSoc` |
| busClav | output | 1 | Cell-available flag for the polled port |
| busClavOe | output | 1 | Drive enable for `busClav` |
| cfgAddr | input | 10 | Port bus addresses, 5 bits per port, port 0 in the low bits |
| cfgFloat | input | 1 | Releases every bus output |
| cellReady | input | 2 | Per port: a complete unstarted cell is buffered |
| bufByte | input | 16 | Per port: the head byte of the buffer, 8 bits each |
| bufRdEn | output | 2 | Per port: pop one byte from the buffer |

## Verification
The poll answer on `busClav` is due one clock edge after the address changes. A transferred byte is due in the cycle after the edge at which the enable is sampled low. The pop strobe `bufRdEn` is combinational and belongs to the cycle before that edge. The bench therefore changes inputs on falling edges. It samples the pop strobe 3 ns after the falling edge and samples the registered outputs 2 ns after the rising edge. Expected bytes go into a queue at the falling edge where the enable is lowered. A monitor pops the queue whenever `busDataOe` is high, so a byte that arrives early, late or unasked is caught as a mismatch or as an unexpected byte.

// File: rtl/mphyRxPkg.sv
`timescale 1ns/1ps
package mphyRxPkg;

  // Width of a port index carried between control and datapath (up to 32 ports).
  localparam int PORT_IDX_W = 5;

  // Strobes from control to datapath for one clock edge.
  typedef struct packed {
    logic                  load;  // pop a byte and capture it for the bus
    logic [PORT_IDX_W-1:0] port;  // which port's buffer byte to capture
    logic                  soc;   // captured byte is offset 0 of its cell
  } xferStrobe_t;

endpackage

// File: rtl/mphyRxCtrl.sv
`timescale 1ns/1ps
module mphyRxCtrl
  import mphyRxPkg::*;
#(
  parameter int NUM_PORTS  = 2,
  parameter int ADDR_W     = 5,
  parameter int CELL_BYTES = 53
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic                        busEnN,
  input  logic [NUM_PORTS*ADDR_W-1:0] cfgAddr,
  input  logic [NUM_PORTS-1:0]        cellReady,
  output logic [NUM_PORTS-1:0]        bufRdEn,
  output xferStrobe_t                 xfer,
  output logic                        clavVal,
  output logic                        clavHit
);

  localparam int OFF_W = $clog2(CELL_BYTES);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(CELL_BYTES - 1);

  logic [NUM_PORTS-1:0]  addrMatch;
  logic [NUM_PORTS-1:0]  portBusy;
  logic [OFF_W-1:0]      offset [NUM_PORTS];
  logic                  hitAny;
  logic [PORT_IDX_W-1:0] hitIdx;
  logic                  hitAvail;
  logic                  selValid;
  logic [PORT_IDX_W-1:0] selPort;
  logic [OFF_W-1:0]      selOffset;
  logic                  selBusy;
  logic                  selReady;
  logic                  canXfer;
  logic                  lastByte;

  // Per-port address compare and byte offset within the current cell.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign addrMatch[p] = (cfgAddr[p*ADDR_W +: ADDR_W] == busAddr);
    assign portBusy[p]  = (offset[p] != '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        offset[p] <= '0;
      end else if (canXfer && (selPort == PORT_IDX_W'(p))) begin
        offset[p] <= (offset[p] == LAST_OFF) ? '0 : offset[p] + OFF_W'(1);
      end
    end
  end

  // Lowest-numbered matching port wins.
  always_comb begin
    hitAny = 1'b0;
    hitIdx = '0;
    for (int p = NUM_PORTS - 1; p >= 0; p--) begin
      if (addrMatch[p]) begin
        hitAny = 1'b1;
        hitIdx = PORT_IDX_W'(p);
      end
    end
  end

  // State of the selected port and of the polled port.
  always_comb begin
    selOffset = '0;
    selBusy   = 1'b0;
    selReady  = 1'b0;
    hitAvail  = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (selPort == PORT_IDX_W'(p)) begin
        selOffset = offset[p];
        selBusy   = portBusy[p];
        selReady  = cellReady[p];
      end
      if (hitIdx == PORT_IDX_W'(p)) begin
        hitAvail = portBusy[p] | cellReady[p];
      end
    end
  end

  assign canXfer  = !busEnN && selValid && (selBusy || selReady);
  assign lastByte = (selOffset == LAST_OFF);

  always_comb begin
    bufRdEn = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      bufRdEn[p] = canXfer && (selPort == PORT_IDX_W'(p));
    end
  end

  assign xfer = '{load: canXfer, port: selPort, soc: (selOffset == '0)};

  // Selection and registered poll answer.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selValid <= 1'b0;
      selPort  <= '0;
      clavHit  <= 1'b0;
      clavVal  <= 1'b0;
    end else begin
      clavHit <= hitAny;
      clavVal <= hitAny && hitAvail;
      if (busEnN) begin
        selValid <= hitAny;
        selPort  <= hitIdx;
      end else if (canXfer && lastByte) begin
        selValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mphyRxData.sv
`timescale 1ns/1ps
module mphyRxData
  import mphyRxPkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int DATA_W    = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  xferStrobe_t                 xfer,
  input  logic [NUM_PORTS*DATA_W-1:0] bufByte,
  input  logic                        cfgFloat,
  input  logic                        clavVal,
  input  logic                        clavHit,
  output logic [DATA_W-1:0]           busData,
  output logic                        busSoc,
  output logic                        busDataOe,
  output logic                        busClav,
  output logic                        busClavOe
);

  logic [DATA_W-1:0] byteSel;
  logic [DATA_W-1:0] dataReg;
  logic              socReg;
  logic              dataValid;

  always_comb begin
    byteSel = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (xfer.port == PORT_IDX_W'(p)) begin
        byteSel = bufByte[p*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataValid <= 1'b0;
      dataReg   <= '0;
      socReg    <= 1'b0;
    end else begin
      dataValid <= xfer.load;
      if (xfer.load) begin
        dataReg <= byteSel;
        socReg  <= xfer.soc;
      end
    end
  end

  assign busData   = dataReg;
  assign busSoc    = socReg && dataValid;
  assign busDataOe = dataValid && !cfgFloat;
  assign busClav   = clavVal;
  assign busClavOe = clavHit && !cfgFloat;

endmodule

// File: rtl/mphyRxPort.sv
`timescale 1ns/1ps
module mphyRxPort
  import mphyRxPkg::*;
#(
  parameter int NUM_PORTS  = 2,
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic                        busEnN,
  output logic [DATA_W-1:0]           busData,
  output logic                        busSoc,
  output logic                        busDataOe,
  output logic                        busClav,
  output logic                        busClavOe,
  input  logic [NUM_PORTS*ADDR_W-1:0] cfgAddr,
  input  logic                        cfgFloat,
  input  logic [NUM_PORTS-1:0]        cellReady,
  input  logic [NUM_PORTS*DATA_W-1:0] bufByte,
  output logic [NUM_PORTS-1:0]        bufRdEn
);

  xferStrobe_t xferS;
  logic        clavVal;
  logic        clavHit;

  mphyRxCtrl #(
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W),
    .CELL_BYTES(CELL_BYTES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busEnN   (busEnN),
    .cfgAddr  (cfgAddr),
    .cellReady(cellReady),
    .bufRdEn  (bufRdEn),
    .xfer     (xferS),
    .clavVal  (clavVal),
    .clavHit  (clavHit)
  );

  mphyRxData #(
    .NUM_PORTS(NUM_PORTS),
    .DATA_W   (DATA_W)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .xfer     (xferS),
    .bufByte  (bufByte),
    .cfgFloat (cfgFloat),
    .clavVal  (clavVal),
    .clavHit  (clavHit),
    .busData  (busData),
    .busSoc   (busSoc),
    .busDataOe(busDataOe),
    .busClav  (busClav),
    .busClavOe(busClavOe)
  );

endmodule

// File: rtl/mphyRxChecker.sv
`timescale 1ns/1ps
module mphyRxChecker #(
  parameter int NUM_PORTS = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busEnN,
  input logic [NUM_PORTS-1:0] bufRdEn,
  input logic                 xferLoad,
  input logic                 xferSoc,
  input logic                 xferLast,
  input logic                 selValid,
  input logic [4:0]           selPort,
  input logic                 dataValid
);

  a_r3_single_pop: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bufRdEn));

  a_r3_enable_gate: assert property (@(posedge clk) disable iff (!rstN)
    (|bufRdEn) |-> !busEnN);

  a_r3_drive_follows: assert property (@(posedge clk) disable iff (!rstN)
    (|bufRdEn) |=> dataValid);

  a_r4_soc_not_last: assert property (@(posedge clk) disable iff (!rstN)
    (xferLoad && xferSoc) |-> !xferLast);

  a_r5_release: assert property (@(posedge clk) disable iff (!rstN)
    (xferLoad && xferLast) |=> !selValid);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busEnN && selValid && !(xferLoad && xferLast)) |=> (selValid && $stable(selPort)));

endmodule

bind mphyRxPort mphyRxChecker #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busEnN   (busEnN),
  .bufRdEn  (bufRdEn),
  .xferLoad (xferS.load),
  .xferSoc  (xferS.soc),
  .xferLast (u_ctrl.lastByte),
  .selValid (u_ctrl.selValid),
  .selPort  (u_ctrl.selPort),
  .dataValid(u_data.dataValid)
);

// File: tb/mphyRxPort_bench.sv
`timescale 1ns/1ps
module mphyRxPort_bench;

  localparam int NP = 2;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int CB = 53;
  localparam logic [4:0] ADDR_A    = 5'd3;
  localparam logic [4:0] ADDR_B    = 5'd17;
  localparam logic [4:0] ADDR_NONE = 5'd9;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [AW-1:0]    busAddr;
  logic             busEnN;
  logic [DW-1:0]    busData;
  logic             busSoc;
  logic             busDataOe;
  logic             busClav;
  logic             busClavOe;
  logic [NP*AW-1:0] cfgAddr;
  logic             cfgFloat;
  logic [NP-1:0]    cellReady;
  logic [NP*DW-1:0] bufByte;
  logic [NP-1:0]    bufRdEn;

  always #4 clk = ~clk;

  mphyRxPort #(.NUM_PORTS(NP), .ADDR_W(AW), .DATA_W(DW), .CELL_BYTES(CB)) u_mphyRxPort (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busEnN(busEnN),
    .busData(busData), .busSoc(busSoc), .busDataOe(busDataOe),
    .busClav(busClav), .busClavOe(busClavOe), .cfgAddr(cfgAddr),
    .cfgFloat(cfgFloat), .cellReady(cellReady), .bufByte(bufByte),
    .bufRdEn(bufRdEn)
  );

  int checks = 0;
  int fails  = 0;
  logic [8:0] expQ [$];
  logic [7:0] bq0 [$];
  logic [7:0] bq1 [$];
  int rdCount [NP];
  int sbOff   [NP];
  int sbCell  [NP];
  int loaded  [NP];
  logic [NP-1:0] rdSnap;

  function automatic logic [7:0] pattern(int p, int c, int o);
    return 8'(p * 97 + c * 31 + o * 5 + 1);
  endfunction

  task automatic chk(bit ok, string req, string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic int qsize(int p);
    return (p == 0) ? bq0.size() : bq1.size();
  endfunction

  // Buffer model: head byte and "complete unstarted cell waiting" flag.
  task automatic refresh();
    for (int p = 0; p < NP; p++) begin
      int rem  = rdCount[p] % CB;
      int pend = qsize(p) - ((rem == 0) ? 0 : CB - rem);
      cellReady[p] = (pend >= CB);
      if (qsize(p) > 0) bufByte[p*DW +: DW] = (p == 0) ? bq0[0] : bq1[0];
      else              bufByte[p*DW +: DW] = '0;
    end
  endtask

  task automatic loadCell(int p);
    for (int o = 0; o < CB; o++) begin
      if (p == 0) bq0.push_back(pattern(p, loaded[p], o));
      else        bq1.push_back(pattern(p, loaded[p], o));
    end
    loaded[p]++;
    refresh();
  endtask

  task automatic pollSel(logic [4:0] a);
    @(negedge clk);
    busAddr = a;
    busEnN  = 1'b1;
    @(posedge clk); #2;
  endtask

  // Driver: hold the enable low for n edges, queue the bytes each should yield.
  task automatic stream(int p, int n, logic [4:0] holdAddr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      busEnN  = 1'b0;
      busAddr = holdAddr;
      if (!cfgFloat) expQ.push_back({sbOff[p] == 0, pattern(p, sbCell[p], sbOff[p])});
      sbOff[p]++;
      if (sbOff[p] == CB) begin
        sbOff[p] = 0;
        sbCell[p]++;
      end
      @(posedge clk); #2;
      if (!cfgFloat)
        chk(busClavOe && busClav, "R6", $sformatf("clav during cell oe=%b val=%b, expected 1/1", busClavOe, busClav));
    end
  endtask

  // Buffer pop model.
  initial begin
    forever begin
      @(negedge clk); #3;
      rdSnap = bufRdEn;
      @(posedge clk); #1;
      if (rdSnap[0] && bq0.size() > 0) begin void'(bq0.pop_front()); rdCount[0]++; end
      if (rdSnap[1] && bq1.size() > 0) begin void'(bq1.pop_front()); rdCount[1]++; end
      refresh();
    end
  end

  // Monitor: every driven byte must match the head of the scoreboard queue.
  initial begin
    logic [8:0] e;
    forever begin
      @(posedge clk); #2;
      if (rstN && busDataOe) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R3", $sformatf("unexpected byte %h, expected none", busData));
        end else begin
          e = expQ.pop_front();
          chk({busSoc, busData} == e, "R3 R4",
              $sformatf("soc/data %b/%h, expected %b/%h", busSoc, busData, e[8], e[7:0]));
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    chk(1'b0, "WD", "watchdog expired: run hung, expected completion");
    report();
  end

  initial begin
    busAddr  = ADDR_NONE;
    busEnN   = 1'b1;
    cfgFloat = 1'b0;
    cfgAddr  = {ADDR_B, ADDR_A};
    for (int p = 0; p < NP; p++) begin
      rdCount[p] = 0; sbOff[p] = 0; sbCell[p] = 0; loaded[p] = 0;
    end
    refresh();

    // R10: reset state
    repeat (2) @(posedge clk);
    #2;
    chk(!busDataOe && !busClavOe && bufRdEn == '0, "R10",
        $sformatf("oe %b/%b rd %b in reset, expected 0/0 00", busDataOe, busClavOe, bufRdEn));
    @(negedge clk);
    rstN = 1'b1;

    // R1: unmatched address leaves clav undriven
    pollSel(ADDR_NONE);
    chk(!busClavOe, "R1", $sformatf("clavOe %b on foreign address, expected 0", busClavOe));

    // R1: matched address, empty buffer
    pollSel(ADDR_A);
    chk(busClavOe && !busClav, "R1", $sformatf("clav oe/val %b/%b empty port, expected 1/0", busClavOe, busClav));

    // R1, R3: cell waiting, enable inactive
    loadCell(0);
    pollSel(ADDR_A);
    chk(busClavOe && busClav, "R1", $sformatf("clav oe/val %b/%b with cell, expected 1/1", busClavOe, busClav));
    chk(!busDataOe, "R3", $sformatf("dataOe %b with enable inactive, expected 0", busDataOe));

    // R4, R5, R6: full cell with a second cell queued
    loadCell(0);
    stream(0, CB, ADDR_A);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); #3;
      chk(bufRdEn == '0, "R5", $sformatf("pop %b after cell end, expected 00", bufRdEn));
      @(posedge clk); #2;
      chk(!busDataOe, "R5", $sformatf("dataOe %b after cell end, expected 0", busDataOe));
    end
    pollSel(ADDR_A);
    chk(busClavOe && busClav, "R6", $sformatf("clav %b with next cell queued, expected 1", busClav));
    stream(0, CB, ADDR_A);
    pollSel(ADDR_A);
    chk(busClavOe && !busClav, "R6", $sformatf("clav %b after last cell, expected 0", busClav));

    // R2, R7: selection holds across address change; interleaved cells
    loadCell(0);
    loadCell(1);
    pollSel(ADDR_B);
    stream(1, 10, ADDR_A);
    pollSel(ADDR_A);
    stream(0, CB, ADDR_A);
    pollSel(ADDR_B);
    chk(busClavOe && busClav, "R7", $sformatf("clav %b for part-sent cell, expected 1", busClav));
    stream(1, CB - 10, ADDR_B);
    pollSel(ADDR_B);
    chk(busClavOe && !busClav, "R7", $sformatf("clav %b after resumed cell, expected 0", busClav));

    // R3: selected port with nothing buffered
    @(negedge clk);
    busEnN = 1'b0;
    #3;
    chk(bufRdEn == '0, "R3", $sformatf("pop %b with empty port, expected 00", bufRdEn));
    @(posedge clk); #2;
    chk(!busDataOe, "R3", $sformatf("dataOe %b with empty port, expected 0", busDataOe));

    // R8: float releases everything, even during a transfer
    loadCell(1);
    cfgFloat = 1'b1;
    pollSel(ADDR_B);
    chk(!busClavOe, "R8", $sformatf("clavOe %b while floating, expected 0", busClavOe));
    stream(1, 1, ADDR_B);
    chk(!busDataOe, "R8", $sformatf("dataOe %b while floating, expected 0", busDataOe));
    cfgFloat = 1'b0;
    pollSel(ADDR_B);
    chk(busClavOe && busClav, "R7", $sformatf("clav %b after floated byte, expected 1", busClav));
    stream(1, CB - 1, ADDR_B);

    // R9: duplicate addresses, lower port wins
    @(negedge clk);
    busEnN  = 1'b1;
    cfgAddr = {ADDR_A, ADDR_A};
    loadCell(1);
    pollSel(ADDR_A);
    chk(busClavOe && !busClav, "R9", $sformatf("clav %b on shared address, expected 0 (port 0 empty)", busClav));
    @(negedge clk);
    busEnN = 1'b0;
    #3;
    chk(bufRdEn == '0, "R9", $sformatf("pop %b on shared address, expected 00", bufRdEn));
    @(negedge clk);
    busEnN  = 1'b1;
    cfgAddr = {ADDR_B, ADDR_A};
    pollSel(ADDR_B);
    chk(busClavOe && busClav, "R9", $sformatf("clav %b for port 1 cell, expected 1", busClav));

    repeat (3) @(posedge clk);
    #2;
    chk(expQ.size() == 0, "R3", $sformatf("%0d bytes never delivered, expected 0", expQ.size()));
    report();
  end

endmodule